// File: doc/BRIEF.md
# Receive Character Queue with DMA Ready Signalling

This block buffers received serial characters between a receiver and a CPU or DMA engine. Each stored entry pairs an 8-bit character with the three error flags (parity, framing, break) the receiver raised for it. The CPU reads the oldest entry through a show-ahead read port and pops it with a one-cycle read strobe. A flush command empties the store. A line-status read strobe clears the sticky overrun flag.

Two operating modes are selectable. In queue mode the store holds `DEPTH` entries. One of four trigger levels raises a trigger-reached flag for the interrupt logic. An active-low ready output drives block transfers with hysteresis: it asserts once the occupancy reaches the trigger level and releases only when the store is empty. In holding mode the store shrinks to a single entry, the ready output simply reports that a character is waiting, and a fresh character replaces an unread one. `DEPTH` must be a power of two, and the trigger levels are derived from it.

Top module: `rxq_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `count` is 0, `ready_n` is 1, `trig_hit` is 0 and `overrun` is 0.
- R2: Entries leave in the order they were written. `rd_data`/`rd_err` always show the oldest stored entry, `rd_en` removes it, and `rd_en` while `count` is 0 has no effect.
- R3: In queue mode (`fifo_en`=1), `count` reports occupancy and never exceeds `DEPTH`. A write while `count`=`DEPTH` without a read in the same cycle is dropped and `count` stays at `DEPTH`. A write together with a read at full is accepted.
- R4: `trig_sel` encodes the trigger level: 2'b00 gives 1 entry, 2'b01 gives DEPTH/4, 2'b10 gives DEPTH/2 and 2'b11 gives DEPTH-2. With DEPTH=16 these are 1, 4, 8 and 14.
- R5: `trig_hit` is 1 exactly when queue mode is on and `count` is at or above the selected level. In holding mode it is 1 exactly when `count` is 1.
- R6: In queue mode, `ready_n` goes low in the same cycle in which `count` first reaches the level. It stays low while `count` is non-zero, even below the level, and returns high in the cycle in which `count` becomes 0.
- R7: In holding mode (`fifo_en`=0), at most one entry is held and `ready_n` is low exactly when `count` is 1.
- R8: In holding mode, a write while an entry is held and not read in that cycle replaces the held entry and sets `overrun`.
- R9: `overrun` is set by a dropped or replaced write and stays set until a cycle with `lsr_rd`=1. If a new overrun coincides with `lsr_rd`, the flag stays set.
- R10: `flush` empties the store in the next cycle (`count`=0, `ready_n`=1). A write in the same cycle is discarded, and `overrun` is not changed by `flush`.
- R11: Any change of `fifo_en` empties the store in the same way as `flush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single holding-entry mode |
| trig_sel | input | 2 | Trigger level select |
| flush | input | 1 | Empty the store |
| wr_en | input | 1 | Receiver write strobe |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error flags of the character: bit 0 parity, bit 1 framing, bit 2 break |
| rd_en | input | 1 | CPU read strobe, pops the oldest entry |
| lsr_rd | input | 1 | Line-status read strobe, clears overrun |
| rd_data | output | 8 | Oldest stored character |
| rd_err | output | 3 | Error flags of the oldest character |
| count | output | 5 | Number of stored entries |
| trig_hit | output | 1 | Trigger level reached, to interrupt logic |
| ready_n | output | 1 | Active-low receive-ready for DMA |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default DEPTH of 16, so the four trigger levels are 1, 4, 8 and 14. A full store of 16 entries is reached within a few writes, which makes drops at full, wrap-around of both pointers, and the hysteresis window between level 14 and empty easy to hit under random traffic. Random mode toggles and level changes in mid-stream exercise the emptying on a mode change and a level change while data sit between the level and empty.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ERR_W  = 3;
    localparam int unsigned WORD_W = DATA_W + ERR_W;

    typedef enum logic [1:0] {
        TRIG_ONE  = 2'b00,
        TRIG_QTR  = 2'b01,
        TRIG_HALF = 2'b10,
        TRIG_NEAR = 2'b11
    } trig_sel_e;

    // Trigger level in entries for a store of the given depth
    function automatic int unsigned trig_level(input logic [1:0] sel,
                                               input int unsigned depth);
        case (trig_sel_e'(sel))
            TRIG_ONE:  return 1;
            TRIG_QTR:  return depth / 4;
            TRIG_HALF: return depth / 2;
            default:   return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 11,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slot_q[waddr] <= wdata;
        end
    end

    assign rdata = slot_q[raddr];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          flush,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          lsr_rd,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW-1:0] mem_raddr,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d,
    output logic          ovr
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovr;
        logic          en;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic          clr, pop, room, push, over;
    logic [CW-1:0] cap;

    always_comb begin
        st_d = st_q;
        clr  = flush || (fifo_en != st_q.en);
        cap  = fifo_en ? CW'(DEPTH) : CW'(1);
        pop  = rd_en && (st_q.cnt != '0);
        room = (st_q.cnt < cap) || pop;
        push = wr_en && room && !clr;
        over = wr_en && !room && !clr;

        st_d.en = fifo_en;
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
            st_d.ovr = st_q.ovr && !lsr_rd;
        end else begin
            if (push) begin
                st_d.wp = st_q.wp + 1'b1;
            end
            if (pop) begin
                st_d.rp = st_q.rp + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
            st_d.ovr = over || (st_q.ovr && !lsr_rd);
        end

        // holding mode replaces the single held entry in place
        mem_we    = push || (over && !fifo_en);
        mem_waddr = push ? st_q.wp : st_q.rp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_raddr = st_q.rp;
    assign cnt_q     = st_q.cnt;
    assign cnt_d     = st_d.cnt;
    assign ovr       = st_q.ovr;

endmodule

// File: rtl/rxq_ready.sv
module rxq_ready #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] cnt_q,
    input  logic [CW-1:0] cnt_d,
    output logic          ready_n,
    output logic          trig_hit
);

    import rxq_pkg::*;

    typedef struct packed {
        logic rdy;
    } rdy_t;

    rdy_t          st_q, st_d;
    logic [CW-1:0] lvl;

    always_comb begin
        st_d = st_q;
        lvl  = CW'(trig_level(trig_sel, DEPTH));
        if (!fifo_en) begin
            st_d.rdy = (cnt_d != '0);
        end else if (cnt_d >= lvl) begin
            st_d.rdy = 1'b1;
        end else if (cnt_d == '0) begin
            st_d.rdy = 1'b0;
        end
        trig_hit = fifo_en ? (cnt_q >= lvl) : (cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_n = !st_q.rdy;

endmodule

// File: rtl/rxq_top.sv
module rxq_top #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fifo_en,
    input  logic [1:0]                trig_sel,
    input  logic                      flush,
    input  logic                      wr_en,
    input  logic [rxq_pkg::DATA_W-1:0] wr_data,
    input  logic [rxq_pkg::ERR_W-1:0]  wr_err,
    input  logic                      rd_en,
    input  logic                      lsr_rd,
    output logic [rxq_pkg::DATA_W-1:0] rd_data,
    output logic [rxq_pkg::ERR_W-1:0]  rd_err,
    output logic [CW-1:0]             count,
    output logic                      trig_hit,
    output logic                      ready_n,
    output logic                      overrun
);

    import rxq_pkg::*;

    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [WORD_W-1:0] rword;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .flush     (flush),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .lsr_rd    (lsr_rd),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_raddr (mem_raddr),
        .cnt_q     (cnt_q),
        .cnt_d     (cnt_d),
        .ovr       (overrun)
    );

    rxq_mem #(.DEPTH(DEPTH), .W(WORD_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata ({wr_err, wr_data}),
        .raddr (mem_raddr),
        .rdata (rword)
    );

    rxq_ready #(.DEPTH(DEPTH)) u_ready (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .ready_n  (ready_n),
        .trig_hit (trig_hit)
    );

    assign rd_data = rword[DATA_W-1:0];
    assign rd_err  = rword[WORD_W-1:DATA_W];
    assign count   = cnt_q;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          flush,
    input logic          wr_en,
    input logic          rd_en,
    input logic          lsr_rd,
    input logic [CW-1:0] count,
    input logic          ready_n,
    input logic          overrun
);

    p_full_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && $past(fifo_en) && count == CW'(DEPTH) && wr_en && !rd_en && !flush)
        |=> (count == CW'(DEPTH) && overrun));

    p_hold_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && $past(!fifo_en)) |-> (count <= CW'(1)));

    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && ready_n));

    p_empty_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> ready_n);

    p_ready_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && $past(fifo_en) && !ready_n && count > CW'(1) && !flush)
        |=> !ready_n);

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !lsr_rd) |=> overrun);

endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (fifo_en),
    .flush   (flush),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .lsr_rd  (lsr_rd),
    .count   (count),
    .ready_n (ready_n),
    .overrun (overrun)
);

// File: tb/sim_rxq_top.sv
module sim_rxq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [1:0] trig_sel = 2'b00;
    logic       flush = 1'b0, wr_en = 1'b0, rd_en = 1'b0, lsr_rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] wr_err = 3'b000;
    logic [7:0] rd_data;
    logic [2:0] rd_err;
    logic [4:0] count;
    logic       trig_hit, ready_n, overrun;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    logic [10:0] mq[$];
    logic        m_ovr = 1'b0, m_rdy = 1'b0, m_en = 1'b0;

    always #2.5 clk = ~clk;

    rxq_top u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .flush(flush), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
        .rd_en(rd_en), .lsr_rd(lsr_rd), .rd_data(rd_data), .rd_err(rd_err),
        .count(count), .trig_hit(trig_hit), .ready_n(ready_n), .overrun(overrun)
    );

    function automatic int lvl_of(input logic [1:0] s);
        case (s)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic clr, pop, room, set;
        int   cap;
        clr  = flush || (fifo_en != m_en);
        cap  = fifo_en ? 16 : 1;
        pop  = rd_en && (mq.size() > 0);
        room = (mq.size() < cap) || pop;
        set  = 1'b0;
        if (clr) begin
            mq.delete();
        end else begin
            if (pop) void'(mq.pop_front());
            if (wr_en) begin
                if (room) mq.push_back({wr_err, wr_data});
                else begin
                    set = 1'b1;
                    if (!fifo_en) mq[0] = {wr_err, wr_data};
                end
            end
        end
        m_ovr = set || (m_ovr && !lsr_rd);
        if (!fifo_en) m_rdy = (mq.size() != 0);
        else if (mq.size() >= lvl_of(trig_sel)) m_rdy = 1'b1;
        else if (mq.size() == 0) m_rdy = 1'b0;
        m_en = fifo_en;
    endtask

    task automatic compare();
        int n;
        n = mq.size();
        chk("R3 count", int'(count), n);
        chk("R6 ready_n", int'(ready_n), int'(!m_rdy));
        chk("R9 overrun", int'(overrun), int'(m_ovr));
        chk("R5 trig_hit", int'(trig_hit),
            fifo_en ? int'(n >= lvl_of(trig_sel)) : int'(n != 0));
        if (n > 0) chk("R2 head", int'({rd_err, rd_data}), int'(mq[0]));
    endtask

    // inputs already set; advance one clock, then sample at the falling edge
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        compare();
        flush = 1'b0; wr_en = 1'b0; rd_en = 1'b0; lsr_rd = 1'b0;
    endtask

    task automatic put(input logic [7:0] d, input logic [2:0] e);
        wr_en = 1'b1; wr_data = d; wr_err = e;
        tick();
    endtask

    task automatic take();
        rd_en = 1'b1;
        tick();
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : main
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        chk("R1 count in reset", int'(count), 0);
        chk("R1 ready_n in reset", int'(ready_n), 1);
        rst_n = 1'b1;
        tick();
        chk("R1 trig_hit after reset", int'(trig_hit), 0);
        chk("R1 overrun after reset", int'(overrun), 0);

        // R4/R6: level 4 in queue mode
        trig_sel = 2'b01;
        for (int i = 0; i < 3; i++) put(8'h10 + 8'(i), 3'(i));
        chk("R6 below level ready_n", int'(ready_n), 1);
        chk("R4 level 4 not hit at 3", int'(trig_hit), 0);
        put(8'h13, 3'b101);
        chk("R6 at level ready_n", int'(ready_n), 0);
        chk("R4 level 4 hit at 4", int'(trig_hit), 1);
        for (int i = 0; i < 3; i++) take();
        chk("R6 held low below level", int'(ready_n), 0);
        chk("R2 last head", int'({rd_err, rd_data}), int'({3'b101, 8'h13}));
        take();
        chk("R6 high when empty", int'(ready_n), 1);
        take();
        chk("R2 read when empty", int'(count), 0);

        // R3/R4/R9: fill to full at level 14
        trig_sel = 2'b11;
        for (int i = 0; i < 13; i++) put(8'h40 + 8'(i), 3'b000);
        chk("R4 level 14 not hit at 13", int'(trig_hit), 0);
        put(8'h4d, 3'b010);
        chk("R4 level 14 hit", int'(trig_hit), 1);
        put(8'h4e, 3'b000);
        put(8'h4f, 3'b000);
        put(8'hee, 3'b111);
        chk("R3 drop at full", int'(count), 16);
        chk("R9 overrun on drop", int'(overrun), 1);
        wr_en = 1'b1; wr_data = 8'h77; rd_en = 1'b1; lsr_rd = 1'b1;
        tick();
        chk("R3 write with read at full", int'(count), 16);
        chk("R9 cleared by status read", int'(overrun), 0);
        for (int i = 0; i < 16; i++) take();
        chk("R6 empty after drain", int'(ready_n), 1);

        // R10: flush with a coincident write
        put(8'h01, 3'b000); put(8'h02, 3'b000);
        flush = 1'b1; wr_en = 1'b1; wr_data = 8'h03;
        tick();
        chk("R10 flush empties", int'(count), 0);
        chk("R10 flush releases ready", int'(ready_n), 1);

        // R11/R7/R8: switch to holding mode with data stored
        put(8'h21, 3'b000); put(8'h22, 3'b000);
        fifo_en = 1'b0;
        tick();
        chk("R11 mode change empties", int'(count), 0);
        put(8'haa, 3'b001);
        chk("R7 holding ready low", int'(ready_n), 0);
        put(8'hbb, 3'b100);
        chk("R8 overwrite keeps count", int'(count), 1);
        chk("R8 newest held", int'({rd_err, rd_data}), int'({3'b100, 8'hbb}));
        chk("R8 overrun set", int'(overrun), 1);
        wr_en = 1'b1; wr_data = 8'hcc; lsr_rd = 1'b1;
        tick();
        chk("R9 set wins over clear", int'(overrun), 1);
        take();
        chk("R7 ready high when empty", int'(ready_n), 1);
        fifo_en = 1'b1;
        tick();

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            wr_en   = ($urandom % 100) < 55;
            wr_data = 8'($urandom);
            wr_err  = 3'($urandom);
            rd_en   = ($urandom % 100) < 42;
            flush   = ($urandom % 100) < 1;
            lsr_rd  = ($urandom % 100) < 5;
            if (($urandom % 100) < 3) trig_sel = 2'($urandom);
            if (($urandom % 1000) < 8) fifo_en = !fifo_en;
            tick();
        end

        finish_run();
    end

endmodule